// File: doc/BRIEF.md
# Boot Mode and External Bus Configuration Sequencer

This block runs once after reset and decides where the processor starts. In the first cycle after reset it takes one sample of an active-low debug-break input and a 4-bit hardware strap. From that sample it hands over a fixed start address for on-chip flash or for the scratchpad RAM that the serial loader fills. If the strap selects external memory, it prepares the external bus and then hands over the external start address. It stops in a permanent halt state for a reserved strap value, or when the break input is active.

External boot needs one extra step before any code is fetched. The block first reads a configuration word from byte offset 4 of the device on chip-select 0. That read uses worst-case bus settings: a 16-bit width, 15 wait states and no burst. These settings work for any memory that may be attached. The block checks the word's fields, replaces any illegal field with its conservative default, and writes the result into the bus settings registers. Only then does it issue the first instruction fetch at the external base address, using the new settings.

The memory side is a request/acknowledge interface. The request is held until the acknowledge arrives. A start address and a one-cycle valid pulse tell the processor where to begin.

Top module: `boot_seq_top`

## Requirements
- R1: The strap and break inputs are sampled only at the first clock edge after rst_ni deasserts; later changes to them have no effect on the chosen path or the handed-over address.
- R2: If the break input dbg_break_ni is low when sampled, the block enters halt (halt_o=1). It then makes no memory request and gives no start-valid pulse.
- R3: With dbg_break_ni high, strap values 4'h3 to 4'hF are reserved. They lead to halt, which lasts with no request and no pulse until the next reset.
- R4: Strap 4'h1 selects flash boot. start_addr_o becomes 0xA000_0000 with no memory request, and start_valid_o pulses at the second clock edge after reset release.
- R5: Strap 4'h2 selects serial-loader boot. start_addr_o becomes 0xD400_0000 with no memory request.
- R6: Strap 4'h0 selects external boot. The first request reads address 0xA100_0004 with width code 1 (16-bit), 15 wait states and burst off.
- R7: The configuration word layout is:
  - bits [1:0]: width (0=8-bit, 1=16-bit, 2=32-bit, 3=illegal, which falls back to 1);
  - bits [5:2]: wait states (0 is illegal and falls back to 15);
  - bit 6: burst enable (forced to 0 when the resolved width is 8-bit);
  - upper bits: ignored.

  The resolved fields appear on mem_width_o, mem_wait_o and mem_burst_o, and stay there after boot.
- R8: After the configuration read is acknowledged, one idle cycle applies the settings. A second request then fetches 0xA100_0000 with the applied settings. When that fetch is acknowledged, start_addr_o becomes 0xA100_0000.
- R9: Every memory request asserts mem_cs0_o.
- R10: start_valid_o is high for exactly one cycle per boot.
- R11: While in reset, no request, halt or valid is output, start_addr_o is 0, and the bus outputs show the conservative settings (width 1, wait 15, burst 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_break_ni | input | 1 | Debug break, active low; high allows normal boot |
| strap_i | input | 4 | Boot selection strap |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_addr_o | output | 32 | Request byte address |
| mem_cs0_o | output | 1 | Chip-select 0 |
| mem_width_o | output | 2 | Bus width code |
| mem_wait_o | output | 4 | Wait states |
| mem_burst_o | output | 1 | Burst enable |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| start_addr_o | output | 32 | Handed-over start address |
| start_valid_o | output | 1 | One-cycle start pulse |
| halt_o | output | 1 | Boot halted |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, a 4-bit strap, a conservative wait count of 15, and the default base addresses. At these values every strap code and every width code can be driven directly, including the reserved ones. The configuration word can also carry the wait value 0, which brings the fallback paths, the burst suppression for 8-bit width and the ignored upper data bits within reach. A memory model that acknowledges after a short delay exposes the configuration read and the first fetch as two separate requests. The bench checks their order and the settings each one carries.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_CFG_READ, ST_CFG_APPLY, ST_FETCH, ST_DONE, ST_HALT
  } boot_state_e;

  typedef enum logic [1:0] {
    PATH_EXT, PATH_FLASH, PATH_SERIAL, PATH_HALT
  } boot_path_e;

  localparam logic [1:0] BW_8  = 2'd0;
  localparam logic [1:0] BW_16 = 2'd1;
  localparam logic [1:0] BW_32 = 2'd2;

  localparam int unsigned CFG_BITS = 7;

  typedef struct packed {
    logic [1:0] width;
    logic [3:0] waits;
    logic       burst;
  } bus_cfg_t;

endpackage

// File: rtl/boot_strap_decode.sv
module boot_strap_decode
  import boot_seq_pkg::*;
#(
  parameter int unsigned      STRAP_W      = 4,
  parameter logic [STRAP_W-1:0] CODE_EXT    = 4'h0,
  parameter logic [STRAP_W-1:0] CODE_FLASH  = 4'h1,
  parameter logic [STRAP_W-1:0] CODE_SERIAL = 4'h2
) (
  input  logic               brk_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output boot_path_e         path_o
);

  always_comb begin
    if (!brk_ni)                    path_o = PATH_HALT;
    else if (strap_i == CODE_EXT)   path_o = PATH_EXT;
    else if (strap_i == CODE_FLASH) path_o = PATH_FLASH;
    else if (strap_i == CODE_SERIAL) path_o = PATH_SERIAL;
    else                            path_o = PATH_HALT;
  end

endmodule

// File: rtl/boot_cfg_decode.sv
module boot_cfg_decode
  import boot_seq_pkg::*;
#(
  parameter logic [3:0] CONS_WAIT = 4'd15
) (
  input  logic [CFG_BITS-1:0] word_i,
  output bus_cfg_t            cfg_o
);

  logic [1:0] raw_width;
  logic [3:0] raw_wait;
  logic       raw_burst;

  assign raw_width = word_i[1:0];
  assign raw_wait  = word_i[5:2];
  assign raw_burst = word_i[6];

  always_comb begin
    cfg_o.width = (raw_width == 2'd3) ? BW_16 : raw_width;
    cfg_o.waits = (raw_wait == 4'd0) ? CONS_WAIT : raw_wait;
    // burst is meaningless on a byte-wide bus
    cfg_o.burst = raw_burst && (cfg_o.width != BW_8);
  end

endmodule

// File: rtl/boot_bus_regs.sv
module boot_bus_regs
  import boot_seq_pkg::*;
#(
  parameter logic [3:0] CONS_WAIT = 4'd15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  bus_cfg_t cfg_i,
  output bus_cfg_t cfg_o
);

  localparam bus_cfg_t CONS_CFG = '{width: BW_16, waits: CONS_WAIT, burst: 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= CONS_CFG;
    else if (load_i) cfg_o <= cfg_i;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o));

  p_wait_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o.waits != 4'd0);

  p_width_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o.width != 2'd3);

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STRAP_W     = 4,
  parameter logic [3:0]  CONS_WAIT   = 4'd15,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] SERIAL_BASE = 32'hD400_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE    = 32'hA100_0000,
  parameter logic [ADDR_W-1:0] CFG_OFFSET  = 32'h0000_0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dbg_break_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_cs0_o,
  output logic [1:0]         mem_width_o,
  output logic [3:0]         mem_wait_o,
  output logic               mem_burst_o,
  input  logic               mem_ack_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [ADDR_W-1:0]  start_addr_o,
  output logic               start_valid_o,
  output logic               halt_o
);

  localparam logic [ADDR_W-1:0] CFG_ADDR = EXT_BASE + CFG_OFFSET;

  boot_state_e         state_q, state_d;
  logic [STRAP_W-1:0]  strap_q;
  logic                brk_q;
  logic [CFG_BITS-1:0] cfg_word_q;
  logic [ADDR_W-1:0]   start_addr_q;
  logic                start_valid_q;
  boot_path_e          path;
  bus_cfg_t            cfg_dec, cfg_cur;
  logic                cfg_load;

  boot_strap_decode #(.STRAP_W(STRAP_W)) u_strap (
    .brk_ni (brk_q),
    .strap_i(strap_q),
    .path_o (path)
  );

  boot_cfg_decode #(.CONS_WAIT(CONS_WAIT)) u_cfg_dec (
    .word_i(cfg_word_q),
    .cfg_o (cfg_dec)
  );

  assign cfg_load = (state_q == ST_CFG_APPLY);

  boot_bus_regs #(.CONS_WAIT(CONS_WAIT)) u_bus_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cfg_load),
    .cfg_i (cfg_dec),
    .cfg_o (cfg_cur)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (path)
          PATH_EXT:    state_d = ST_CFG_READ;
          PATH_FLASH,
          PATH_SERIAL: state_d = ST_DONE;
          default:     state_d = ST_HALT;
        endcase
      end
      ST_CFG_READ:  if (mem_ack_i) state_d = ST_CFG_APPLY;
      ST_CFG_APPLY: state_d = ST_FETCH;
      ST_FETCH:     if (mem_ack_i) state_d = ST_DONE;
      ST_DONE:      state_d = ST_DONE;
      ST_HALT:      state_d = ST_HALT;
      default:      state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      strap_q       <= '0;
      brk_q         <= 1'b1;
      cfg_word_q    <= '0;
      start_addr_q  <= '0;
      start_valid_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      start_valid_q <= (state_d == ST_DONE) && (state_q != ST_DONE);
      if (state_q == ST_IDLE) begin
        strap_q <= strap_i;
        brk_q   <= dbg_break_ni;
      end
      if (state_q == ST_CFG_READ && mem_ack_i)
        cfg_word_q <= mem_rdata_i[CFG_BITS-1:0];
      if (state_q == ST_DECODE && path == PATH_FLASH)  start_addr_q <= FLASH_BASE;
      if (state_q == ST_DECODE && path == PATH_SERIAL) start_addr_q <= SERIAL_BASE;
      if (state_q == ST_FETCH && mem_ack_i)            start_addr_q <= EXT_BASE;
    end
  end

  assign mem_req_o     = (state_q == ST_CFG_READ) || (state_q == ST_FETCH);
  assign mem_addr_o    = (state_q == ST_CFG_READ) ? CFG_ADDR : EXT_BASE;
  assign mem_cs0_o     = mem_req_o;
  assign mem_width_o   = cfg_cur.width;
  assign mem_wait_o    = cfg_cur.waits;
  assign mem_burst_o   = cfg_cur.burst;
  assign start_addr_o  = start_addr_q;
  assign start_valid_o = start_valid_q;
  assign halt_o        = (state_q == ST_HALT);

  p_path_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(path));

  p_halt_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !mem_req_o && !start_valid_o));

  p_cfg_read_safe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CFG_READ) |-> (mem_width_o == BW_16 && mem_wait_o == CONS_WAIT
                                  && !mem_burst_o));

  p_fetch_after_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> ($past(state_q) == ST_CFG_APPLY || $past(state_q) == ST_FETCH));

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |=> !start_valid_o);

  p_valid_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |-> (start_addr_o != '0));

endmodule

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ACK_DLY    = 2;
  localparam int RUN_CYC    = 40;

  typedef struct packed {
    logic        brk;
    logic [3:0]  strap;
    logic [31:0] word;
    logic        ext;
    logic        halt;
    logic [31:0] addr;
    logic [1:0]  w;
    logic [3:0]  wt;
    logic        b;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 32'h0000_004E, 1'b1, 1'b0, 32'hA100_0000, 2'd2, 4'd3,  1'b1},
    '{1'b1, 4'h0, 32'h0000_0003, 1'b1, 1'b0, 32'hA100_0000, 2'd1, 4'd15, 1'b0},
    '{1'b1, 4'h0, 32'h0000_0054, 1'b1, 1'b0, 32'hA100_0000, 2'd0, 4'd5,  1'b0},
    '{1'b1, 4'h0, 32'hFFFF_FF89, 1'b1, 1'b0, 32'hA100_0000, 2'd1, 4'd2,  1'b0},
    '{1'b1, 4'h1, 32'h0000_004E, 1'b0, 1'b0, 32'hA000_0000, 2'd1, 4'd15, 1'b0},
    '{1'b1, 4'h2, 32'h0000_004E, 1'b0, 1'b0, 32'hD400_0000, 2'd1, 4'd15, 1'b0},
    '{1'b1, 4'h7, 32'h0000_004E, 1'b0, 1'b1, 32'h0000_0000, 2'd1, 4'd15, 1'b0},
    '{1'b1, 4'hF, 32'h0000_004E, 1'b0, 1'b1, 32'h0000_0000, 2'd1, 4'd15, 1'b0},
    '{1'b0, 4'h0, 32'h0000_004E, 1'b0, 1'b1, 32'h0000_0000, 2'd1, 4'd15, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brk_n = 1'b1;
  logic [3:0]  strap = 4'h0;
  logic        req, cs0, burst, ack, svalid, halt;
  logic [31:0] addr, rdata, saddr;
  logic [1:0]  width;
  logic [3:0]  waits;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [31:0] mem_word = '0;

  // request log
  int          n_req, n_valid, valid_cyc;
  logic [31:0] r_addr [2];
  logic [1:0]  r_w    [2];
  logic [3:0]  r_wt   [2];
  logic        r_b    [2];
  logic        r_cs   [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_break_ni(brk_n), .strap_i(strap),
    .mem_req_o(req), .mem_addr_o(addr), .mem_cs0_o(cs0), .mem_width_o(width),
    .mem_wait_o(waits), .mem_burst_o(burst), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .start_addr_o(saddr), .start_valid_o(svalid), .halt_o(halt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // run RUN_CYC cycles after reset release with a delayed-ack memory model
  task automatic run_boot(input int chg_at, input logic [3:0] new_strap, input logic new_brk);
    int  wcnt = 0;
    logic prev_req = 1'b0;
    n_req = 0; n_valid = 0; valid_cyc = -1;
    ack = 1'b0; rdata = '0;
    @(negedge clk) rst_n = 1'b1;
    for (int c = 0; c < RUN_CYC; c++) begin
      @(negedge clk);
      if (c == chg_at) begin strap = new_strap; brk_n = new_brk; end
      if (svalid) begin n_valid++; valid_cyc = c; end
      if (req && !prev_req && n_req < 2) begin
        r_addr[n_req] = addr; r_w[n_req] = width; r_wt[n_req] = waits;
        r_b[n_req] = burst; r_cs[n_req] = cs0;
        n_req++;
      end
      if (req && !cs0) chk("R9 cs0 with request", 32'(cs0), 32'd1);
      prev_req = req;
      if (ack) begin ack = 1'b0; wcnt = 0; prev_req = 1'b0; end
      else if (req) begin
        wcnt++;
        if (wcnt >= ACK_DLY) begin
          ack = 1'b1;
          rdata = (addr == 32'hA100_0004) ? mem_word : 32'hDEAD_BEEF;
        end
      end
    end
  endtask

  task automatic do_reset(input logic b, input logic [3:0] s);
    @(negedge clk);
    rst_n = 1'b0; brk_n = b; strap = s; ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    ack = 1'b0; rdata = '0;
    // R11 reset state
    @(negedge clk);
    chk("R11 req in reset",   32'(req), 0);
    chk("R11 halt in reset",  32'(halt), 0);
    chk("R11 valid in reset", 32'(svalid), 0);
    chk("R11 start addr",     saddr, 0);
    chk("R11 width",          32'(width), 1);
    chk("R11 wait",           32'(waits), 15);
    chk("R11 burst",          32'(burst), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      mem_word = v.word;
      do_reset(v.brk, v.strap);
      run_boot(-1, v.strap, v.brk);
      chk(v.halt ? (v.brk ? "R3 halt" : "R2 halt") : "R3 no halt", 32'(halt), 32'(v.halt));
      chk("R10 one valid pulse", n_valid, v.halt ? 0 : 1);
      chk("R7 width out", 32'(width), 32'(v.w));
      chk("R7 wait out",  32'(waits), 32'(v.wt));
      chk("R7 burst out", 32'(burst), 32'(v.b));
      if (v.halt) begin
        chk("R2/R3 no request", n_req, 0);
      end else begin
        chk(v.ext ? "R8 start addr" : (v.strap == 4'h1 ? "R4 start addr" : "R5 start addr"),
            saddr, v.addr);
      end
      if (v.ext) begin
        chk("R6 two requests", n_req, 2);
        chk("R6 cfg addr",  r_addr[0], 32'hA100_0004);
        chk("R6 cfg width", 32'(r_w[0]), 1);
        chk("R6 cfg wait",  32'(r_wt[0]), 15);
        chk("R6 cfg burst", 32'(r_b[0]), 0);
        chk("R9 cfg cs0",   32'(r_cs[0]), 1);
        chk("R8 fetch addr",  r_addr[1], 32'hA100_0000);
        chk("R8 fetch width", 32'(r_w[1]), 32'(v.w));
        chk("R8 fetch wait",  32'(r_wt[1]), 32'(v.wt));
        chk("R8 fetch burst", 32'(r_b[1]), 32'(v.b));
        chk("R9 fetch cs0",   32'(r_cs[1]), 1);
      end else if (!v.halt) begin
        chk("R4/R5 no request", n_req, 0);
      end
    end

    // R4 timing: valid seen at negedge after 2nd edge -> loop index 1
    do_reset(1'b1, 4'h1);
    run_boot(-1, 4'h1, 1'b1);
    chk("R4 valid timing", valid_cyc, 1);

    // R1: change strap and break right after sampling edge
    do_reset(1'b1, 4'h1);
    run_boot(0, 4'hF, 1'b0);
    chk("R1 strap change ignored halt", 32'(halt), 0);
    chk("R1 strap change ignored addr", saddr, 32'hA000_0000);
    chk("R1 one valid", n_valid, 1);

    // R3: reserved strap stays halted even if strap becomes legal
    do_reset(1'b1, 4'h5);
    run_boot(3, 4'h0, 1'b1);
    chk("R3 halt persists", 32'(halt), 1);
    chk("R3 no request after halt", n_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule